// File: doc/BRIEF.md
# Maskable Interrupt Response Sequencer

This block sits next to a small 8-bit processor core with a 16-bit address space. It handles the maskable interrupt. The core reports each instruction boundary. If a level request is present and the primary enable flag is set at that boundary, the sequencer takes the request and clears both enable flags. It then runs a fixed-length acknowledge bus cycle and carries out one of three responses, chosen by a 2-bit mode input:

- **Opcode injection.** The byte captured during acknowledge goes to the core's decoder, and program-counter advance stays frozen.
- **Fixed restart.** The return address is pushed and the program counter moves to a constant address.
- **Vectored jump.** A pointer is formed from a page register and the acknowledged byte. A 16-bit target is read through that pointer, the return address is pushed, and execution jumps to the target.

The memory side is a plain strobe bus with a fixed cycle count per access. It has no valid/ready handshake and no back-pressure, because the cost of each response in clocks is part of the contract. The bus always accepts an access in the clock it is presented. Read data must be valid on the last clock of each access and is sampled there. The core holds `pc_i`, `sp_i` and `page_i` stable at the accepting boundary; the sequencer captures them in that clock. `mode_i` is also sampled at that boundary. In the clock where `done_o` is high, the core loads `pc_new_o` and, when `pc_load_o` is high, `sp_new_o` too.

Top module: `irq_resp_seq`

## Requirements
- R1: A request is accepted only in a clock where `boundary_i`, `irq_i` and `ie1_o` are all high and the sequencer is idle. `busy_o` rises in the following clock. No other combination starts a sequence.
- R2: Acceptance clears both `ie1_o` and `ie2_o` from the next clock on. `ien_set_i` sets both flags and `ien_clr_i` clears both; if both are high, clear wins. Both flags come out of reset low.
- R3: Call the clock after acceptance cycle 1. In cycles 1 to 6, `ack_o` is high, `mem_rd_o` and `mem_wr_o` are low, and `addr_o` carries the captured PC. `rdata_i` is sampled at the end of cycle 6. At most one of `ack_o`, `mem_rd_o` and `mem_wr_o` is high in any clock.
- R4: Mode value 0 selects injection, 2 selects the vectored jump, and both 1 and 3 select the restart.
- R5: Restart and vectored responses push the return address in two writes of 3 clocks each, with `mem_wr_o` high. Cycles 7 to 9 write PC[15:8] to SP-1. Cycles 10 to 12 write PC[7:0] to SP-2. Addresses wrap modulo 2^16, so SP=0x0000 writes 0xFFFF and then 0xFFFE. `sp_new_o` is SP-2.
- R6: The restart response takes 13 clocks. `done_o` and `pc_load_o` are high in cycle 13 with `pc_new_o` = 0x0038, and `busy_o` is low in cycle 14.
- R7: The vectored response takes 19 clocks. The pointer is {page, acknowledged byte}. Cycles 13 to 15 read the target's low byte at the pointer, with `mem_rd_o` high. Cycles 16 to 18 read the high byte at pointer+1, which carries into the page byte. In cycle 19, `done_o` and `pc_load_o` are high with `pc_new_o` = {high, low}.
- R8: The injection response takes 7 clocks. In cycle 7, `done_o` and `inj_valid_o` are high, `inj_op_o` holds the acknowledged byte, `pc_load_o` is low and `pc_new_o` equals the captured PC. `pc_hold_o` is high from cycle 7 until the clock after the next clock in which `boundary_i` is high.
- R9: A request present while `busy_o` is high is ignored. After a sequence, nothing starts again until R1 holds again.
- R10: `done_o` is a single-clock pulse, exactly one per sequence, in its last cycle.
- R11: After reset, the sequencer is idle: all strobes, `busy_o`, `done_o`, `pc_hold_o` and both enable flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Level interrupt request |
| boundary_i | input | 1 | Core is at an instruction boundary |
| ien_set_i | input | 1 | Set both enable flags |
| ien_clr_i | input | 1 | Clear both enable flags |
| mode_i | input | 2 | Response mode select |
| page_i | input | 8 | Vector page register |
| pc_i | input | 16 | Core program counter |
| sp_i | input | 16 | Core stack pointer |
| rdata_i | input | 8 | Bus read data / acknowledge byte |
| ack_o | output | 1 | Interrupt acknowledge strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_o | output | 16 | Bus address |
| wdata_o | output | 8 | Bus write data |
| busy_o | output | 1 | A response sequence is in progress |
| done_o | output | 1 | Last-cycle pulse of a sequence |
| pc_load_o | output | 1 | Core loads `pc_new_o` and `sp_new_o` |
| pc_new_o | output | 16 | New program counter |
| sp_new_o | output | 16 | New stack pointer |
| inj_valid_o | output | 1 | Injected opcode is valid |
| inj_op_o | output | 8 | Injected opcode |
| pc_hold_o | output | 1 | Suppress PC advance during the injected instruction |
| ie1_o | output | 1 | Primary interrupt-enable flag |
| ie2_o | output | 1 | Secondary interrupt-enable flag |

## Verification
The bench builds the block with its defaults: 6-clock acknowledge, 3-clock memory accesses and restart address 0x0038. These values make the exact 7-, 13- and 19-clock response lengths observable clock by clock. Random PC, SP, page and acknowledge bytes cover many pointer and stack placements. Directed cases reach a stack pointer of zero, where the push wraps to the top of memory, and an acknowledge byte of 0xFF, where the pointer increment carries into the page byte.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_PUSH_H,
    ST_PUSH_L,
    ST_VEC_L,
    ST_VEC_H,
    ST_FIN
  } seq_st_e;

  typedef enum logic [1:0] {
    RESP_INJ,
    RESP_RST,
    RESP_VEC
  } resp_e;

  // Value 3 is folded onto the restart response.
  function automatic resp_e decode_mode(input logic [1:0] m);
    case (m)
      2'd0:    return RESP_INJ;
      2'd2:    return RESP_VEC;
      default: return RESP_RST;
    endcase
  endfunction

endpackage

// File: rtl/irq_accept.sv
module irq_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic boundary_i,
  input  logic ien_set_i,
  input  logic ien_clr_i,
  input  logic idle_i,
  output logic start_o,
  output logic ie1_o,
  output logic ie2_o
);

  logic ie1_q, ie2_q;

  assign start_o = idle_i & boundary_i & irq_i & ie1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie1_q <= 1'b0;
      ie2_q <= 1'b0;
    end else if (start_o || ien_clr_i) begin
      ie1_q <= 1'b0;
      ie2_q <= 1'b0;
    end else if (ien_set_i) begin
      ie1_q <= 1'b1;
      ie2_q <= 1'b1;
    end
  end

  assign ie1_o = ie1_q;
  assign ie2_o = ie2_q;

  AST_ACCEPT_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (!ie1_q && !ie2_q)); // R2

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int ACK_CLKS = 6,
  parameter int MEM_CLKS = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  resp_e   resp_i,
  input  logic    boundary_i,
  output seq_st_e state_o,
  output resp_e   resp_o,
  output logic    last_o,
  output logic    pc_hold_o
);

  localparam int MAXC = (ACK_CLKS > MEM_CLKS) ? ACK_CLKS : MEM_CLKS;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] ACK_LAST = CW'(ACK_CLKS - 1);
  localparam logic [CW-1:0] MEM_LAST = CW'(MEM_CLKS - 1);

  seq_st_e        st_q, st_d;
  resp_e          resp_q;
  logic [CW-1:0]  cnt_q;
  logic           hold_q;
  logic           last;

  always_comb begin
    case (st_q)
      ST_ACK:                                  last = (cnt_q == ACK_LAST);
      ST_PUSH_H, ST_PUSH_L, ST_VEC_L, ST_VEC_H: last = (cnt_q == MEM_LAST);
      default:                                 last = 1'b1;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_ACK;
      ST_ACK:    if (last) st_d = (resp_q == RESP_INJ) ? ST_FIN : ST_PUSH_H;
      ST_PUSH_H: if (last) st_d = ST_PUSH_L;
      ST_PUSH_L: if (last) st_d = (resp_q == RESP_VEC) ? ST_VEC_L : ST_FIN;
      ST_VEC_L:  if (last) st_d = ST_VEC_H;
      ST_VEC_H:  if (last) st_d = ST_FIN;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      resp_q <= RESP_RST;
      cnt_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_d != st_q) ? '0 : cnt_q + 1'b1;
      if (start_i) resp_q <= resp_i;
    end
  end

  // Frozen PC window for the injected instruction.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (st_q == ST_FIN && resp_q == RESP_INJ) begin
      hold_q <= 1'b1;
    end else if (st_q == ST_IDLE && boundary_i) begin
      hold_q <= 1'b0;
    end
  end

  assign state_o   = st_q;
  assign resp_o    = resp_q;
  assign last_o    = last;
  assign pc_hold_o = hold_q | (st_q == ST_FIN && resp_q == RESP_INJ);

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (st_q == ST_IDLE)); // R9
  AST_FIN_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIN) |=> (st_q == ST_IDLE)); // R10
  AST_ACK_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACK && cnt_q == ACK_LAST) |=> (st_q != ST_ACK)); // R3

endmodule

// File: rtl/irq_bus_drv.sv
module irq_bus_drv
  import irq_seq_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          DW      = 8,
  parameter logic [AW-1:0] RST_VEC = 16'h0038
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  seq_st_e       state_i,
  input  resp_e         resp_i,
  input  logic          last_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] page_i,
  input  logic [DW-1:0] rdata_i,
  output logic          ack_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          done_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_new_o,
  output logic [AW-1:0] sp_new_o,
  output logic          inj_valid_o,
  output logic [DW-1:0] inj_op_o
);

  logic [AW-1:0] pc_q, sp_q;
  logic [DW-1:0] page_q, ackb_q, lo_q, hi_q;
  logic [AW-1:0] ptr, ptr_p1, sp_m1, sp_m2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      sp_q   <= '0;
      page_q <= '0;
      ackb_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (start_i) begin
        pc_q   <= pc_i;
        sp_q   <= sp_i;
        page_q <= page_i;
      end
      if (state_i == ST_ACK   && last_i) ackb_q <= rdata_i;
      if (state_i == ST_VEC_L && last_i) lo_q   <= rdata_i;
      if (state_i == ST_VEC_H && last_i) hi_q   <= rdata_i;
    end
  end

  generate
    if (AW > 2 * DW) begin : g_ptr_pad
      assign ptr = {{(AW - 2 * DW){1'b0}}, page_q, ackb_q};
    end else begin : g_ptr_cut
      logic [2*DW-1:0] ptr_full;
      assign ptr_full = {page_q, ackb_q};
      assign ptr      = ptr_full[AW-1:0];
    end
  endgenerate

  assign ptr_p1 = ptr + 1'b1;
  assign sp_m1  = sp_q - 1'b1;
  assign sp_m2  = sp_q - 2'd2;

  always_comb begin
    ack_o    = 1'b0;
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    addr_o   = pc_q;
    wdata_o  = '0;
    case (state_i)
      ST_ACK: ack_o = 1'b1;
      ST_PUSH_H: begin
        mem_wr_o = 1'b1;
        addr_o   = sp_m1;
        wdata_o  = pc_q[AW-1 -: DW];
      end
      ST_PUSH_L: begin
        mem_wr_o = 1'b1;
        addr_o   = sp_m2;
        wdata_o  = pc_q[DW-1:0];
      end
      ST_VEC_L: begin
        mem_rd_o = 1'b1;
        addr_o   = ptr;
      end
      ST_VEC_H: begin
        mem_rd_o = 1'b1;
        addr_o   = ptr_p1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (resp_i)
      RESP_RST: pc_new_o = RST_VEC;
      RESP_VEC: pc_new_o = AW'({hi_q, lo_q});
      default:  pc_new_o = pc_q;
    endcase
  end

  assign done_o      = (state_i == ST_FIN);
  assign pc_load_o   = done_o && (resp_i != RESP_INJ);
  assign inj_valid_o = done_o && (resp_i == RESP_INJ);
  assign inj_op_o    = ackb_q;
  assign sp_new_o    = sp_m2;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_o, mem_rd_o, mem_wr_o})); // R3
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && $past(mem_wr_o) && state_i == $past(state_i)) |-> $stable(wdata_o)); // R5
  AST_VEC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && resp_i == RESP_VEC) |-> ($past(state_i) == ST_VEC_H)); // R7

endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
  import irq_seq_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter int            ACK_CLKS = 6,
  parameter int            MEM_CLKS = 3,
  parameter logic [AW-1:0] RST_VEC  = 16'h0038
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_i,
  input  logic          boundary_i,
  input  logic          ien_set_i,
  input  logic          ien_clr_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] page_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] rdata_i,
  output logic          ack_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_new_o,
  output logic [AW-1:0] sp_new_o,
  output logic          inj_valid_o,
  output logic [DW-1:0] inj_op_o,
  output logic          pc_hold_o,
  output logic          ie1_o,
  output logic          ie2_o
);

  seq_st_e state;
  resp_e   resp_q;
  logic    start, last;

  irq_accept u_accept (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_i      (irq_i),
    .boundary_i (boundary_i),
    .ien_set_i  (ien_set_i),
    .ien_clr_i  (ien_clr_i),
    .idle_i     (state == ST_IDLE),
    .start_o    (start),
    .ie1_o      (ie1_o),
    .ie2_o      (ie2_o)
  );

  irq_seq_ctrl #(
    .ACK_CLKS (ACK_CLKS),
    .MEM_CLKS (MEM_CLKS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .resp_i     (decode_mode(mode_i)),
    .boundary_i (boundary_i),
    .state_o    (state),
    .resp_o     (resp_q),
    .last_o     (last),
    .pc_hold_o  (pc_hold_o)
  );

  irq_bus_drv #(
    .AW      (AW),
    .DW      (DW),
    .RST_VEC (RST_VEC)
  ) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .state_i     (state),
    .resp_i      (resp_q),
    .last_i      (last),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .page_i      (page_i),
    .rdata_i     (rdata_i),
    .ack_o       (ack_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .addr_o      (addr_o),
    .wdata_o     (wdata_o),
    .done_o      (done_o),
    .pc_load_o   (pc_load_o),
    .pc_new_o    (pc_new_o),
    .sp_new_o    (sp_new_o),
    .inj_valid_o (inj_valid_o),
    .inj_op_o    (inj_op_o)
  );

  assign busy_o = (state != ST_IDLE);

  AST_BUSY_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(ie1_o && boundary_i && irq_i)); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_HOLD_AFTER_INJ: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid_o |-> pc_hold_o); // R8

endmodule

// File: tb/irq_resp_seq_tb_top.sv
module irq_resp_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq, boundary, ien_set, ien_clr;
  logic [1:0]  mode;
  logic [7:0]  page, ack_byte;
  logic [15:0] pc, sp;
  logic [7:0]  rdata;
  logic        ack, mrd, mwr, busy, done, pc_load, inj_valid, pc_hold, ie1, ie2;
  logic [15:0] addr, pc_new, sp_new;
  logic [7:0]  wdata, inj_op;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign rdata = ack ? ack_byte : memf(addr);

  irq_resp_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .boundary_i(boundary),
    .ien_set_i(ien_set), .ien_clr_i(ien_clr), .mode_i(mode), .page_i(page),
    .pc_i(pc), .sp_i(sp), .rdata_i(rdata), .ack_o(ack), .mem_rd_o(mrd),
    .mem_wr_o(mwr), .addr_o(addr), .wdata_o(wdata), .busy_o(busy),
    .done_o(done), .pc_load_o(pc_load), .pc_new_o(pc_new), .sp_new_o(sp_new),
    .inj_valid_o(inj_valid), .inj_op_o(inj_op), .pc_hold_o(pc_hold),
    .ie1_o(ie1), .ie2_o(ie2)
  );

  typedef struct packed {
    logic        ack, rd, wr, done;
    logic [15:0] addr;
    logic [7:0]  wd;
  } bus_t;

  // 0 = inject, 1 = restart, 2 = vectored (R4)
  function automatic int resp_of(input logic [1:0] m);
    return (m == 2'd0) ? 0 : (m == 2'd2) ? 2 : 1;
  endfunction

  function automatic bus_t exp_bus(input int r, input int k, input logic [15:0] p,
                                   input logic [15:0] s, input logic [15:0] ptr);
    bus_t e;
    int   last;
    e = '0;
    last = (r == 0) ? 7 : (r == 1) ? 13 : 19;
    if (k <= 6) begin
      e.ack = 1'b1; e.addr = p;
    end else if (k == last) begin
      e.done = 1'b1;
    end else if (k <= 9) begin
      e.wr = 1'b1; e.addr = s - 16'd1; e.wd = p[15:8];
    end else if (k <= 12) begin
      e.wr = 1'b1; e.addr = s - 16'd2; e.wd = p[7:0];
    end else if (k <= 15) begin
      e.rd = 1'b1; e.addr = ptr;
    end else begin
      e.rd = 1'b1; e.addr = ptr + 16'd1;
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic [1:0] m, input logic [15:0] p, input logic [15:0] s,
                         input logic [7:0] pg, input logic [7:0] ab);
    int          r, last;
    logic [15:0] ptr;
    bus_t        e;
    @(negedge clk); ien_set = 1'b1;
    @(negedge clk); ien_set = 1'b0;
    mode = m; pc = p; sp = s; page = pg; ack_byte = ab;
    irq = 1'b1; boundary = 1'b1;
    r = resp_of(m);
    last = (r == 0) ? 7 : (r == 1) ? 13 : 19;
    ptr = {pg, ab};
    @(negedge clk); boundary = 1'b0;
    chk("R2 ie1 cleared", {31'd0, ie1}, 32'd0);
    chk("R2 ie2 cleared", {31'd0, ie2}, 32'd0);
    for (int k = 1; k <= last; k++) begin
      if (k > 1) @(negedge clk);
      e = exp_bus(r, k, p, s, ptr);
      chk("R9 busy in sequence", {31'd0, busy}, 32'd1);
      chk("R3 ack strobe", {31'd0, ack}, {31'd0, e.ack});
      chk("R7 read strobe", {31'd0, mrd}, {31'd0, e.rd});
      chk("R5 write strobe", {31'd0, mwr}, {31'd0, e.wr});
      chk("R10 done timing", {31'd0, done}, {31'd0, e.done});
      if (e.ack || e.rd || e.wr) chk("R5 bus address", {16'd0, addr}, {16'd0, e.addr});
      if (e.wr) chk("R5 write data", {24'd0, wdata}, {24'd0, e.wd});
      if (k == last) begin
        if (r == 0) begin
          chk("R8 inj valid", {31'd0, inj_valid}, 32'd1);
          chk("R8 inj opcode", {24'd0, inj_op}, {24'd0, ab});
          chk("R8 no pc load", {31'd0, pc_load}, 32'd0);
          chk("R8 pc unchanged", {16'd0, pc_new}, {16'd0, p});
          chk("R8 hold in fin", {31'd0, pc_hold}, 32'd1);
        end else begin
          chk("R6 pc load", {31'd0, pc_load}, 32'd1);
          chk("R5 sp new", {16'd0, sp_new}, {16'd0, s - 16'd2});
          if (r == 1) chk("R6 restart target", {16'd0, pc_new}, 32'h0038);
          else chk("R7 vector target", {16'd0, pc_new},
                   {16'd0, memf(ptr + 16'd1), memf(ptr)});
          chk("R4 no injection", {31'd0, inj_valid}, 32'd0);
        end
      end
    end
    @(negedge clk);
    chk("R6 busy ends", {31'd0, busy}, 32'd0);
    chk("R10 single done", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R9 no restart without boundary", {31'd0, busy}, 32'd0);
    irq = 1'b0;
    if (r == 0) begin
      chk("R8 hold persists", {31'd0, pc_hold}, 32'd1);
      @(negedge clk); boundary = 1'b1;
      chk("R8 hold before boundary", {31'd0, pc_hold}, 32'd1);
      @(negedge clk); boundary = 1'b0;
      chk("R8 hold released", {31'd0, pc_hold}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; irq = 0; boundary = 0; ien_set = 0; ien_clr = 0;
    mode = 0; page = 0; ack_byte = 0; pc = 0; sp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 strobes", {29'd0, ack, mrd, mwr}, 32'd0);
    chk("R11 done/hold", {30'd0, done, pc_hold}, 32'd0);
    chk("R11 flags", {30'd0, ie1, ie2}, 32'd0);
    // R1: flag low blocks acceptance
    irq = 1; boundary = 1;
    repeat (3) @(negedge clk);
    chk("R1 blocked by ie1", {31'd0, busy}, 32'd0);
    boundary = 0; ien_set = 1;
    @(negedge clk); ien_set = 0;
    chk("R2 set flags", {30'd0, ie1, ie2}, 32'd3);
    repeat (2) @(negedge clk);
    chk("R1 blocked by no boundary", {31'd0, busy}, 32'd0);
    ien_set = 1; ien_clr = 1;
    @(negedge clk); ien_set = 0; ien_clr = 0;
    chk("R2 clear wins", {30'd0, ie1, ie2}, 32'd0);
    boundary = 1;
    @(negedge clk); boundary = 0;
    chk("R1 blocked after clear", {31'd0, busy}, 32'd0);
    irq = 0;
    // directed corners
    run_seq(2'd1, 16'h0102, 16'h0000, 8'h00, 8'hFF);   // R5 SP wrap, R6
    run_seq(2'd2, 16'h0102, 16'h0000, 8'h02, 8'h21);   // R7
    run_seq(2'd2, 16'hABCD, 16'h8000, 8'h12, 8'hFF);   // R7 page carry
    run_seq(2'd3, 16'h4321, 16'h0001, 8'h00, 8'h00);   // R4 mode 3
    run_seq(2'd0, 16'h0102, 16'h1000, 8'h00, 8'h21);   // R8
    for (int i = 0; i < 40; i++) begin
      run_seq(2'($urandom()), 16'($urandom()), 16'($urandom()),
              8'($urandom()), 8'($urandom()));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule